// File: doc/BRIEF.md
# Byte-Window SPI Command Engine

This block is an SPI host that software drives through eight byte-wide registers. Software first loads an opcode, up to three address bytes and one outgoing data byte. It then writes a control byte that picks the serial clock rate, the number of response bytes (zero to three) and a two-bit write-length code. The engine asserts chip select and shifts the selected write bytes out MSB first in a fixed order. It then clocks in the response bytes and releases chip select. While this runs, a busy flag reads back as 1.

The serial side runs in SPI mode 0. The shifted data changes only while the clock is low, and the incoming line is sampled on each rising edge. The write phase and the read phase follow each other with no idle clocks between them.

The sequencer has five states:
- `ST_IDLE`: chip select is high.
- `ST_LEAD`: the first half-period with chip select low.
- `ST_HIGH`: the clock is high.
- `ST_LOW`: the clock is low between bits.
- `ST_TAIL`: the half-period after the last falling edge.

Its transitions are:
- IDLE→LEAD on an accepted start.
- LEAD→HIGH on a divider tick.
- HIGH→LOW on a tick when more bits remain.
- HIGH→TAIL on a tick after the last bit.
- LOW→HIGH on a tick.
- TAIL→IDLE on a tick.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the data-out line is low and offset 0 reads 0x00.
- R2: A write to offset 0 while idle starts a transfer. The control byte fields are: bits [7:4] speed, bits [3:2] read count (0..3) and bits [1:0] write-length code. Bit 7 of offset 0 reads 1 from the first clock after that write until the cycle chip select rises, and reads 0 otherwise.
- R3: The write-length code sets the number of bytes sent. Code 0 sends 1 byte, code 1 sends 2, code 2 sends 4 and code 3 sends 5.
- R4: The opcode at offset 1 is always the first byte on the wire. Code 1 sends offset 7 next. Codes 2 and 3 send offsets 4, 3 and 2 in that order after the opcode, and code 3 then sends offset 7.
- R5: The serial interface is mode 0 and MSB first. The data-out line changes only while the serial clock is low, and the data-in line is sampled on rising edges.
- R6: Response bytes are stored in arrival order at offsets 5, 6 and 7. An offset beyond the read count keeps its previous value.
- R7: A write to offset 7 updates only the outgoing data byte. A read of offset 7 always returns the third received byte.
- R8: One serial half-period lasts HALF_UNIT×(16 − speed) system clocks. With the default HALF_UNIT of 1, speed 5 gives 11 clocks.
- R9: The first rising edge comes one half-period after chip select falls, and chip select rises one half-period after the last falling edge. Each transfer has exactly 8×(write bytes + read bytes) rising edges.
- R10: A write to offset 0 while busy is ignored, and the running transfer continues unchanged.
- R11: With read count 0, the transfer ends right after the last write bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Chip select falls on the clock edge that samples the start write, so the busy flag reads 1 at the next falling system-clock edge. The bench reads it there. The first rising serial edge is due one half-period later, and each bit takes two half-periods. The last received byte is stored one system clock after its final sample, which is at least one half-period before busy clears. For that reason the bench reads offsets 5 to 7 only after polling busy back to 0. The bench timestamps the chip-select and serial-clock edges and converts the gaps into clock counts. It compares those counts with the half-period that R8 gives for the chosen speed.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int SPEED_W  = 4;
    localparam int MAX_WR   = 5;
    localparam int MAX_RD   = 3;
    localparam int TX_W     = DATA_W * MAX_WR;
    localparam int BIT_W    = $clog2(DATA_W * (MAX_WR + MAX_RD) + 1);
    localparam int RIDX_W   = $clog2(MAX_RD);

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_OPC   = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_ADR_C = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_ADR_B = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_ADR_A = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_RSP0  = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_RSP1  = 3'd6;
    localparam logic [ADDR_W-1:0] OFF_DATA  = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } seq_state_e;

    typedef struct packed {
        logic [SPEED_W-1:0] speed;
        logic [1:0]         rd_cnt;
        logic [1:0]         wr_code;
    } ctrl_t;

    function automatic logic [2:0] wr_len_of(input logic [1:0] code);
        unique case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
    parameter int HALF_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);

    logic [HALF_W-1:0] cnt;

    assign tick = !clr && (cnt == half - HALF_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + HALF_W'(1);
        end
    end

    // R8: the count never runs past the selected half-period
    a_r8_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (cnt < half));

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic [MAX_RD-1:0] rx_we,
    input  logic [DATA_W-1:0] rx_data,
    output logic              start_req,
    output logic [DATA_W-1:0] opc_q,
    output logic [DATA_W-1:0] adr_a_q,
    output logic [DATA_W-1:0] adr_b_q,
    output logic [DATA_W-1:0] adr_c_q,
    output logic [DATA_W-1:0] dout_q
);

    logic [DATA_W-1:0] rsp_q [MAX_RD];

    assign start_req = bus_wr && (bus_addr == OFF_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_q   <= '0;
            adr_a_q <= '0;
            adr_b_q <= '0;
            adr_c_q <= '0;
            dout_q  <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                OFF_OPC:   opc_q   <= bus_wdata;
                OFF_ADR_A: adr_a_q <= bus_wdata;
                OFF_ADR_B: adr_b_q <= bus_wdata;
                OFF_ADR_C: adr_c_q <= bus_wdata;
                OFF_DATA:  dout_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < MAX_RD; g++) begin : g_rsp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rsp_q[g] <= '0;
            end else if (rx_we[g]) begin
                rsp_q[g] <= rx_data;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_CTRL:  bus_rdata = {busy, {(DATA_W-1){1'b0}}};
            OFF_OPC:   bus_rdata = opc_q;
            OFF_ADR_C: bus_rdata = adr_c_q;
            OFF_ADR_B: bus_rdata = adr_b_q;
            OFF_ADR_A: bus_rdata = adr_a_q;
            OFF_RSP0:  bus_rdata = rsp_q[0];
            OFF_RSP1:  bus_rdata = rsp_q[1];
            default:   bus_rdata = rsp_q[MAX_RD-1];
        endcase
    end

    // R6: at most one response slot is written per cycle
    a_r6_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_we));

    // R7: a bus write to offset 7 never disturbs the third received byte
    a_r7_split_storage: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_DATA && !rx_we[MAX_RD-1])
            |=> $stable(rsp_q[MAX_RD-1]));

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int HALF_UNIT = 1,
    parameter int HALF_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [DATA_W-1:0] ctrl_in,
    input  logic [DATA_W-1:0] opc,
    input  logic [DATA_W-1:0] adr_a,
    input  logic [DATA_W-1:0] adr_b,
    input  logic [DATA_W-1:0] adr_c,
    input  logic [DATA_W-1:0] dout,
    input  logic              tick,
    input  logic              miso,
    output logic              div_clr,
    output logic [HALF_W-1:0] half,
    output logic              busy,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    output logic [MAX_RD-1:0] rx_we,
    output logic [DATA_W-1:0] rx_data
);

    localparam int SPD_LVLS = 1 << SPEED_W;

    seq_state_e         state, state_nx;
    ctrl_t              ctrl;
    logic [TX_W-1:0]    tx_sh, tx_load;
    logic [DATA_W-1:0]  rx_sh;
    logic [BIT_W-1:0]   bit_cnt, total_bits, wr_bits;
    logic [BIT_W-1:0]   wr_bits_n, rd_bits_n;
    logic [RIDX_W-1:0]  rd_idx;
    logic [HALF_W-1:0]  half_q, half_n;
    logic               accept, last_bit, sample, in_read;

    assign ctrl      = ctrl_t'(ctrl_in);
    assign accept    = start_req && (state == ST_IDLE);
    assign last_bit  = (bit_cnt == total_bits - BIT_W'(1));
    assign wr_bits_n = BIT_W'(wr_len_of(ctrl.wr_code)) << 3;
    assign rd_bits_n = BIT_W'(ctrl.rd_cnt) << 3;
    assign half_n    = HALF_W'(HALF_UNIT * (SPD_LVLS - int'(ctrl.speed)));
    assign sample    = tick && ((state == ST_LEAD) || (state == ST_LOW));
    assign in_read   = (bit_cnt >= wr_bits);
    assign rd_idx    = RIDX_W'((bit_cnt - wr_bits) >> 3);
    assign half      = half_q;

    always_comb begin
        unique case (ctrl.wr_code)
            2'd0:    tx_load = {opc, {(4*DATA_W){1'b0}}};
            2'd1:    tx_load = {opc, dout, {(3*DATA_W){1'b0}}};
            2'd2:    tx_load = {opc, adr_a, adr_b, adr_c, {DATA_W{1'b0}}};
            default: tx_load = {opc, adr_a, adr_b, adr_c, dout};
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_LEAD;
            ST_LEAD: if (tick)   state_nx = ST_HIGH;
            ST_HIGH: if (tick)   state_nx = last_bit ? ST_TAIL : ST_LOW;
            ST_LOW:  if (tick)   state_nx = ST_HIGH;
            ST_TAIL: if (tick)   state_nx = ST_IDLE;
            default:             state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy    = (state != ST_IDLE);
        cs_n    = (state == ST_IDLE);
        sck     = (state == ST_HIGH);
        mosi    = (state != ST_IDLE) && tx_sh[TX_W-1];
        div_clr = (state == ST_IDLE);
    end

    // shift and capture datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh      <= '0;
            rx_sh      <= '0;
            bit_cnt    <= '0;
            total_bits <= '0;
            wr_bits    <= '0;
            half_q     <= HALF_W'(HALF_UNIT * SPD_LVLS);
            rx_we      <= '0;
            rx_data    <= '0;
        end else begin
            rx_we <= '0;
            if (accept) begin
                tx_sh      <= tx_load;
                bit_cnt    <= '0;
                wr_bits    <= wr_bits_n;
                total_bits <= wr_bits_n + rd_bits_n;
                half_q     <= half_n;
            end
            if (sample) begin
                rx_sh <= {rx_sh[DATA_W-2:0], miso};
                if (in_read && (bit_cnt[2:0] == 3'd7)) begin
                    rx_we   <= MAX_RD'(1) << rd_idx;
                    rx_data <= {rx_sh[DATA_W-2:0], miso};
                end
            end
            if ((state == ST_HIGH) && tick && !last_bit) begin
                tx_sh   <= tx_sh << 1;
                bit_cnt <= bit_cnt + BIT_W'(1);
            end
        end
    end

    // R5: data-out holds while the serial clock is high
    a_r5_mosi_held: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));

    // R9: the bit index stays inside the programmed transfer length
    a_r9_bit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bit_cnt < total_bits));

    // R11: the trailing half-period only follows the final bit
    a_r11_tail_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |-> last_bit);

    // R10: a start while busy leaves the running transfer untouched
    a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && state != ST_IDLE) |=> ($stable(total_bits) && $stable(half_q)));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int HALF_UNIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int HALF_W = $clog2(HALF_UNIT * (1 << SPEED_W) + 1);

    logic              busy, start_req, div_clr, tick;
    logic [HALF_W-1:0] half;
    logic [MAX_RD-1:0] rx_we;
    logic [DATA_W-1:0] rx_data;
    logic [DATA_W-1:0] opc_q, adr_a_q, adr_b_q, adr_c_q, dout_q;

    spi_cmd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .rx_we     (rx_we),
        .rx_data   (rx_data),
        .start_req (start_req),
        .opc_q     (opc_q),
        .adr_a_q   (adr_a_q),
        .adr_b_q   (adr_b_q),
        .adr_c_q   (adr_c_q),
        .dout_q    (dout_q)
    );

    spi_cmd_clkdiv #(.HALF_W(HALF_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .half  (half),
        .tick  (tick)
    );

    spi_cmd_seq #(.HALF_UNIT(HALF_UNIT), .HALF_W(HALF_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .ctrl_in   (bus_wdata),
        .opc       (opc_q),
        .adr_a     (adr_a_q),
        .adr_b     (adr_b_q),
        .adr_c     (adr_c_q),
        .dout      (dout_q),
        .tick      (tick),
        .miso      (spi_miso),
        .div_clr   (div_clr),
        .half      (half),
        .busy      (busy),
        .sck       (spi_sck),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .rx_we     (rx_we),
        .rx_data   (rx_data)
    );

    // R1/R9: the serial clock only toggles inside a chip-select window
    a_r9_sck_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

endmodule

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    spi_cmd_engine u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    // ---------------- device model ----------------
    int         dev_wr = 1;
    logic [7:0] dev_resp [3];
    logic [7:0] cap [8];
    int         rise_cnt = 0;
    realtime    t_csfall, t_rise1, t_rise2, t_lastfall, t_csrise;

    function automatic logic resp_bit(input int k);
        int idx;
        idx = k - dev_wr * 8;
        if (idx < 0 || idx >= 24) return 1'b0;
        return dev_resp[idx / 8][7 - (idx % 8)];
    endfunction

    always @(negedge spi_cs_n) begin
        t_csfall = $realtime;
        rise_cnt = 0;
        for (int i = 0; i < 8; i++) cap[i] = 8'h00;
        spi_miso = resp_bit(0);
    end

    always @(posedge spi_cs_n) t_csrise = $realtime;

    always @(posedge spi_sck) begin
        if (rise_cnt == 0) t_rise1 = $realtime;
        if (rise_cnt == 1) t_rise2 = $realtime;
        if (rise_cnt < 64) cap[rise_cnt / 8] = {cap[rise_cnt / 8][6:0], spi_mosi};
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge spi_sck) begin
        t_lastfall = $realtime;
        spi_miso = resp_bit(rise_cnt);
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 5000; i++) begin
            bus_read(3'd0, v);
            if (!v[7]) return;
        end
    endtask

    function automatic int wr_len(input logic [1:0] code);
        case (code)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 5;
        endcase
    endfunction

    task automatic xfer(input logic [7:0] op, a4, a3, a2, d7,
                        input logic [3:0] spd, input logic [1:0] rd, input logic [1:0] code);
        dev_wr = wr_len(code);
        bus_write(3'd1, op);
        bus_write(3'd4, a4);
        bus_write(3'd3, a3);
        bus_write(3'd2, a2);
        bus_write(3'd7, d7);
        bus_write(3'd0, {spd, rd, code});
        wait_idle();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [7:0] v;
        bus_read(3'd0, v);
        chk("R1 offset0 after reset", v, 8'h00);
        chk("R1 cs_n idle", spi_cs_n, 1);
        chk("R1 sck idle", spi_sck, 0);
        chk("R1 mosi idle", spi_mosi, 0);
    endtask

    task automatic t_ident();
        logic [7:0] v;
        dev_resp[0] = 8'hC2; dev_resp[1] = 8'h20; dev_resp[2] = 8'h13;
        xfer(8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 4'hF, 2'd3, 2'd0);
        chk("R4 opcode first", cap[0], 8'h9F);
        chk("R9 edges 1w3r", rise_cnt, 32);
        bus_read(3'd5, v); chk("R6 rsp byte0", v, 8'hC2);
        bus_read(3'd6, v); chk("R6 rsp byte1", v, 8'h20);
        bus_read(3'd7, v); chk("R6 rsp byte2", v, 8'h13);
    endtask

    task automatic t_two_byte();
        logic [7:0] v;
        xfer(8'h06, 8'h00, 8'h00, 8'h00, 8'hA5, 4'hF, 2'd0, 2'd1);
        chk("R3 R11 edges code1 rd0", rise_cnt, 16);
        chk("R4 code1 byte0", cap[0], 8'h06);
        chk("R4 code1 byte1 from off7", cap[1], 8'hA5);
        bus_read(3'd7, v); chk("R7 off7 reads rx not tx", v, 8'h13);
    endtask

    task automatic t_four_byte();
        logic [7:0] v;
        dev_resp[0] = 8'h5A; dev_resp[1] = 8'h6B; dev_resp[2] = 8'hFF;
        xfer(8'h03, 8'h11, 8'h22, 8'h33, 8'h00, 4'hF, 2'd2, 2'd2);
        chk("R3 edges code2 rd2", rise_cnt, 48);
        chk("R4 code2 byte1 off4", cap[1], 8'h11);
        chk("R4 code2 byte2 off3", cap[2], 8'h22);
        chk("R4 code2 byte3 off2", cap[3], 8'h33);
        chk("R5 read after write no gap", cap[4], 8'h00);
        bus_read(3'd5, v); chk("R6 rd2 byte0", v, 8'h5A);
        bus_read(3'd6, v); chk("R6 rd2 byte1", v, 8'h6B);
        bus_read(3'd7, v); chk("R6 unread slot retained", v, 8'h13);
    endtask

    task automatic t_five_byte();
        logic [7:0] v;
        xfer(8'h02, 8'h44, 8'h55, 8'h66, 8'h77, 4'hF, 2'd0, 2'd3);
        chk("R3 edges code3", rise_cnt, 40);
        chk("R4 code3 byte1", cap[1], 8'h44);
        chk("R4 code3 byte3", cap[3], 8'h66);
        chk("R4 code3 byte4 off7", cap[4], 8'h77);
        bus_read(3'd7, v); chk("R7 off7 write kept apart", v, 8'h13);
    endtask

    task automatic t_busy();
        logic [7:0] v;
        dev_wr = 1;
        bus_write(3'd1, 8'hB7);
        bus_write(3'd0, 8'hF0);
        bus_read(3'd0, v);
        chk("R2 busy bit set", v[7], 1);
        bus_write(3'd0, 8'hFF);
        wait_idle();
        chk("R10 start while busy ignored", rise_cnt, 8);
        chk("R10 byte unchanged", cap[0], 8'hB7);
        bus_read(3'd0, v);
        chk("R2 busy cleared", v, 8'h00);
    endtask

    task automatic t_timing();
        xfer(8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 4'h5, 2'd1, 2'd0);
        chk("R8 R9 cs to first rise clocks", int'((t_rise1 - t_csfall) / 5.0), 11);
        chk("R8 sck period clocks", int'((t_rise2 - t_rise1) / 5.0), 22);
        chk("R9 last fall to cs rise clocks", int'((t_csrise - t_lastfall) / 5.0), 11);
        chk("R9 edges 1w1r", rise_cnt, 16);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_two_byte();
        t_four_byte();
        t_five_byte();
        t_busy();
        t_timing();
        summary();
        $finish;
    end

endmodule